// File: doc/BRIEF.md
# Paged Disk Window Mapper

This block lets a small CPU reach a large flash-based disk store through a fixed 8 KB hole in its memory map. The 56 KB of RAM fills addresses 0x0000 to 0xDFFF, and the top 8 KB, 0xE000 to 0xFFFF, is the disk window. Software picks the disk and the 8 KB slice within it by writing a page register through an I/O port. After that, plain loads and stores inside the window reach the chosen slice of flash.

Each disk holds 256 KB: 2048 flash pages of 128 bytes, or 128 tracks of 16 sectors. A disk therefore spans 32 window-sized pages. The low five bits of the page register pick the page. The next two bits pick one of four disks. The block builds the 18-bit flash address from the page number and the CPU's low address bits. It also drives a one-hot disk select. Both outputs are live only while a memory read or write falls inside the window. Software can read the same port back to see the current page register.

Top module: `disk_window_mapper`

## Requirements
- R1: After reset the page register holds zero (disk 0, page 0), and a read of the port returns 0x00.
- R2: A cycle with `io_wr` high and `io_addr` equal to the port address (default 0x44) loads `io_wdata[6:0]` at that clock edge. The new value is in effect in the next cycle. An `io_wr` to any other address leaves the register unchanged.
- R3: Bit 7 of a written byte is ignored. It is not stored and always reads back as 0.
- R4: While `io_rd` is high and `io_addr` equals the port address, `io_rdata` is {0, page register} in the same cycle. Otherwise `io_rdata` is 0x00.
- R5: `win_hit` is 1 exactly when `mem_rd` or `mem_wr` is high and `mem_addr[15:13]` is 3'b111.
- R6: While `win_hit` is 1, `flash_addr` equals {page register bits 4:0, `mem_addr[12:0]`}. Page register bits 4:0 are the page within the disk, and they land on flash address bits 17:13.
- R7: While `win_hit` is 1, `disk_sel` has exactly one bit set, at index page register bits 6:5. Those bits are the disk number, from 0 to 3.
- R8: While `win_hit` is 0, `flash_addr` and `disk_sel` are both zero. This covers RAM-range accesses and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_addr | input | 8 | I/O port address |
| io_wr | input | 1 | I/O write strobe |
| io_rd | input | 1 | I/O read strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data (page register on port match) |
| mem_addr | input | 16 | CPU memory address |
| mem_rd | input | 1 | Memory read strobe |
| mem_wr | input | 1 | Memory write strobe |
| win_hit | output | 1 | Memory access falls inside the disk window |
| flash_addr | output | 18 | Flash address for the selected disk |
| disk_sel | output | 4 | One-hot disk select |

## Verification
Random page bytes are written, some with bit 7 set, and writes are aimed both at the port and at nearby addresses. This separates a correct address match and bit-7 masking from a register that loads on any write. Memory accesses are drawn across the whole 64 KB space with random read/write strobes. Directed addresses at 0xDFFF, 0xE000 and 0xFFFF test the window edge, and they separate the window decode from an off-by-one or a wrong bit slice. Every disk number and the extreme pages 0 and 31 are visited, which exposes a swapped page and disk field or a mis-ordered one-hot.

// File: rtl/dwm_pkg.sv
package dwm_pkg;
  localparam int CPU_AW    = 16;
  localparam int WIN_BITS  = 3;
  localparam int PAGE_BITS = 5;
  localparam int DISK_BITS = 2;
  localparam int IO_W      = 8;

  // true when the top address bits equal the window tag
  function automatic logic tag_match(input logic [WIN_BITS-1:0] top,
                                     input logic [WIN_BITS-1:0] tag);
    return top == tag;
  endfunction
endpackage

// File: rtl/dwm_page_reg.sv
module dwm_page_reg #(
  parameter int IO_W    = 8,
  parameter int REG_W   = 7,
  parameter logic [IO_W-1:0] PORT = 8'h44
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IO_W-1:0] io_addr,
  input  logic            io_wr,
  input  logic            io_rd,
  input  logic [IO_W-1:0] io_wdata,
  output logic [REG_W-1:0] page_q,
  output logic [IO_W-1:0] io_rdata
);
  logic port_sel;
  logic load;
  assign port_sel = (io_addr == PORT);
  assign load     = io_wr && port_sel;

  always_ff @(posedge clk) begin
    if (!rst_n)     page_q <= '0;
    else if (load)  page_q <= io_wdata[REG_W-1:0];
  end

  assign io_rdata = (io_rd && port_sel) ? IO_W'(page_q) : '0;

  // R2: a matching write lands on the next edge
  a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> page_q == $past(io_wdata[REG_W-1:0]));
  // R2: no matching write, register holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(page_q));
  // R3: top bit never reads back as one
  a_r3_top_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rdata[IO_W-1]);
endmodule

// File: rtl/dwm_window_decode.sv
module dwm_window_decode
  import dwm_pkg::*;
#(
  parameter int AW = 16,
  parameter logic [WIN_BITS-1:0] TAG = '1
) (
  input  logic [AW-1:0] mem_addr,
  input  logic          mem_rd,
  input  logic          mem_wr,
  output logic          hit
);
  logic strobe;
  assign strobe = mem_rd || mem_wr;
  assign hit = strobe && tag_match(mem_addr[AW-1 -: WIN_BITS], TAG);

  // R5: no strobe, no hit
  always_comb begin
    a_r5_needs_strobe: assert (strobe || !hit);
  end
endmodule

// File: rtl/dwm_addr_map.sv
module dwm_addr_map #(
  parameter int OFS_W     = 13,
  parameter int PAGE_BITS = 5,
  parameter int DISK_BITS = 2,
  localparam int NDISK    = 1 << DISK_BITS,
  localparam int REG_W    = PAGE_BITS + DISK_BITS,
  localparam int FA_W     = PAGE_BITS + OFS_W
) (
  input  logic             hit,
  input  logic [REG_W-1:0] page_q,
  input  logic [OFS_W-1:0] offset,
  output logic [FA_W-1:0]  flash_addr,
  output logic [NDISK-1:0] disk_sel
);
  logic [PAGE_BITS-1:0] page_no;
  logic [DISK_BITS-1:0] disk_no;
  assign page_no = page_q[PAGE_BITS-1:0];
  assign disk_no = page_q[REG_W-1:PAGE_BITS];

  assign flash_addr = hit ? {page_no, offset} : '0;

  for (genvar g = 0; g < NDISK; g++) begin : g_sel
    assign disk_sel[g] = hit && (disk_no == DISK_BITS'(g));
  end

  // R7: select is one-hot exactly when hit
  always_comb begin
    a_r7_onehot: assert ($countones(disk_sel) == (hit ? 1 : 0));
  end
endmodule

// File: rtl/disk_window_mapper.sv
module disk_window_mapper
  import dwm_pkg::*;
#(
  parameter int AW        = CPU_AW,
  parameter int PAGE_W    = PAGE_BITS,
  parameter int DISK_W    = DISK_BITS,
  parameter int IOW       = IO_W,
  parameter logic [IO_W-1:0] PORT = 8'h44,
  localparam int OFS_W    = AW - WIN_BITS,
  localparam int REG_W    = PAGE_W + DISK_W,
  localparam int FA_W     = PAGE_W + OFS_W,
  localparam int NDISK    = 1 << DISK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IOW-1:0]   io_addr,
  input  logic             io_wr,
  input  logic             io_rd,
  input  logic [IOW-1:0]   io_wdata,
  output logic [IOW-1:0]   io_rdata,
  input  logic [AW-1:0]    mem_addr,
  input  logic             mem_rd,
  input  logic             mem_wr,
  output logic             win_hit,
  output logic [FA_W-1:0]  flash_addr,
  output logic [NDISK-1:0] disk_sel
);
  logic [REG_W-1:0] page_q;

  dwm_page_reg #(.IO_W(IOW), .REG_W(REG_W), .PORT(PORT)) u_reg (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_rd(io_rd), .io_wdata(io_wdata), .page_q(page_q), .io_rdata(io_rdata)
  );

  dwm_window_decode #(.AW(AW)) u_dec (
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .hit(win_hit)
  );

  dwm_addr_map #(.OFS_W(OFS_W), .PAGE_BITS(PAGE_W), .DISK_BITS(DISK_W)) u_map (
    .hit(win_hit), .page_q(page_q), .offset(mem_addr[OFS_W-1:0]),
    .flash_addr(flash_addr), .disk_sel(disk_sel)
  );

  // R8: outputs quiet outside the window
  a_r8_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !win_hit |-> (flash_addr == '0 && disk_sel == '0));
  // R6: low flash bits follow the CPU offset during a hit
  a_r6_offset: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> flash_addr[OFS_W-1:0] == mem_addr[OFS_W-1:0]);
endmodule

// File: tb/disk_window_mapper_bench.sv
module disk_window_mapper_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] io_addr = 0, io_wdata = 0, io_rdata;
  logic io_wr = 0, io_rd = 0, mem_rd = 0, mem_wr = 0, win_hit;
  logic [15:0] mem_addr = 0;
  logic [17:0] flash_addr;
  logic [3:0] disk_sel;
  int checks = 0, errors = 0;
  logic [6:0] mp = 0;   // model page register

  always #2.5 clk = ~clk;

  disk_window_mapper u_disk_window_mapper (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .mem_addr(mem_addr),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .win_hit(win_hit),
    .flash_addr(flash_addr), .disk_sel(disk_sel));

  function automatic logic exp_hit(input logic [15:0] a, input logic r, input logic w);
    return (r | w) && (a >= 16'hE000);
  endfunction
  function automatic logic [17:0] exp_fa(input logic [6:0] p, input logic [15:0] a);
    return 18'(p % 32) * 18'h2000 + 18'(a % 16'h2000);
  endfunction
  function automatic logic [3:0] exp_sel(input logic [6:0] p);
    return 4'(1 << (p / 32));
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic io_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    io_addr = a; io_wdata = d; io_wr = 1;
    @(negedge clk);
    io_wr = 0;
    if (a == 8'h44) mp = d[6:0];
  endtask

  task automatic io_read(input logic [7:0] a, input string req);
    @(negedge clk);
    io_addr = a; io_rd = 1;
    #1;
    check(req, 32'(io_rdata), (a == 8'h44) ? {25'd0, mp} : 32'd0);
    io_rd = 0;
  endtask

  task automatic mem_access(input logic [15:0] a, input logic r, input logic w);
    logic h;
    @(negedge clk);
    mem_addr = a; mem_rd = r; mem_wr = w;
    #1;
    h = exp_hit(a, r, w);
    check("R5 win_hit", 32'(win_hit), 32'(h));
    if (h) begin
      check("R6 flash_addr", 32'(flash_addr), 32'(exp_fa(mp, a)));
      check("R7 disk_sel", 32'(disk_sel), 32'(exp_sel(mp)));
    end else begin
      check("R8 quiet flash_addr", 32'(flash_addr), 32'd0);
      check("R8 quiet disk_sel", 32'(disk_sel), 32'd0);
    end
    mem_rd = 0; mem_wr = 0;
  endtask

  initial begin
    #(5 * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4242);
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    io_read(8'h44, "R1 reset readback");
    mem_access(16'hE123, 1, 0);
    // R2 directed load and foreign-port write
    io_write(8'h44, 8'h25);
    io_read(8'h44, "R2 load");
    io_write(8'h45, 8'h7F);
    io_read(8'h44, "R2 foreign write ignored");
    // R3 bit 7 dropped
    io_write(8'h44, 8'hFF);
    io_read(8'h44, "R3 bit7 dropped");
    mem_access(16'hFFFF, 0, 1);
    // R4 read at other port returns zero
    io_read(8'h43, "R4 other port zero");
    // R5/R8 window edges
    mem_access(16'hDFFF, 1, 0);
    mem_access(16'hE000, 1, 0);
    mem_access(16'hE000, 0, 0);
    // R7 every disk, extreme pages
    for (int d = 0; d < 4; d++) begin
      io_write(8'h44, 8'(d * 32));
      mem_access(16'hE001, 1, 0);
      io_write(8'h44, 8'(d * 32 + 31));
      mem_access(16'hFFFE, 0, 1);
    end
    // random mix
    for (int i = 0; i < 300; i++) begin
      int unsigned op;
      op = $urandom % 3;
      if (op == 0)
        io_write(($urandom % 2) ? 8'h44 : 8'($urandom), 8'($urandom));
      else if (op == 1)
        io_read(($urandom % 2) ? 8'h44 : 8'($urandom), "R4 random read");
      else
        mem_access(16'($urandom), 1'($urandom), 1'($urandom));
    end
    // R1 reset again clears register
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1; mp = 0;
    io_read(8'h44, "R1 second reset");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule